// File: doc/BRIEF.md
# Receive Reset Sequencer for Serial Transceiver Channels

This block drives the receive-side reset outputs for a bank of serial transceiver channels. Each channel gets three registered outputs: an analog reset for the clock-data-recovery circuit and the receive analog front end, a digital reset for the receive datapath, and a ready flag. The analog reset follows the global reset and the channel's calibration-busy input. The digital reset stays high while the channel is not usable. Once every holding condition has cleared, it is released only after a per-channel settle countdown. The ready flag follows a few cycles after that release.

The calibration-busy and CDR locked-to-data inputs come from other clock domains. Each one passes through a two-flop synchronizer before use. A manual-mode input tells the sequencer to ignore loss of CDR lock. Each channel runs its own sequence, so a disturbance on one channel leaves the others untouched. All timing below counts rising clock edges after an input changes between edges.

Top module: `rx_reset_seq`

## Requirements
- R1: `anaRst[c]` is high while `rstIn` is high. After reset it equals channel c's calibration-busy input, delayed by three rising edges (two synchronizer stages plus the output register).
- R2: `digRst[c]` is high while any of these holds: `rstIn`, `anaRst[c]`, synchronized calibration-busy, or (in automatic mode) synchronized CDR lock low. It is never low while `anaRst[c]` is high.
- R3: With the holding conditions cleared, a counter of `SETTLE_CYCLES` runs before `digRst[c]` falls. After `rstIn` is released with lock present, `digRst[c]` falls on the `SETTLE_CYCLES+3`rd rising edge.
- R4: `chanReady[c]` is low whenever `digRst[c]` is high. It rises exactly `READY_DELAY` rising edges after `digRst[c]` falls, and it falls on the same edge that `digRst[c]` rises.
- R5: If a holding condition returns during the countdown, the counter reloads and `digRst[c]` stays high. A one-cycle loss of raw lock delays the release to `SETTLE_CYCLES+4` edges after the loss began.
- R6: With `manualMode` = 1, loss of CDR lock does not raise `digRst[c]` and does not drop `chanReady[c]`. Calibration-busy still raises both resets.
- R7: Raising `rstIn` sets all `anaRst` and `digRst` bits and clears all `chanReady` bits at once, without waiting for a clock edge. Release takes effect on the clock.
- R8: Channels are independent. Lock loss or calibration on one channel leaves every other channel's `digRst` and `chanReady` unchanged.
- R9: `anaRst`, `digRst`, `chanReady`, `calBusyIn` and `cdrLockedIn` are each `NUM_CHAN` bits wide, with bit c belonging to channel c.
- R10: Loss of raw lock in automatic mode raises `digRst[c]` on the third rising edge. A rising calibration-busy raises `anaRst[c]` and `digRst[c]` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all outputs are registered on it |
| rstIn | input | 1 | Global reset, active high, asserts asynchronously |
| calBusyIn | input | NUM_CHAN | Per-channel calibration busy, asynchronous |
| cdrLockedIn | input | NUM_CHAN | Per-channel CDR locked-to-data, asynchronous |
| manualMode | input | 1 | 1 = ignore CDR lock loss as a digital reset condition |
| anaRst | output | NUM_CHAN | Per-channel analog receive reset |
| digRst | output | NUM_CHAN | Per-channel digital receive reset |
| chanReady | output | NUM_CHAN | Per-channel receive-ready flag |

## Verification
The assertions assume that `manualMode` changes only when nothing depends on it on that edge. They also assume that `rstIn` is the only asynchronous path into the output registers. The asynchronous status inputs only need to be stable long enough to cross the two synchronizer stages. The bench changes every input on the falling clock edge, so each synchronizer sees a clean level on the next rising edge and the expected edge counts are exact. It toggles `manualMode` only while the affected channel's lock input is steady, and it holds each status level for at least one full cycle.

// File: rtl/rx_reset_seq_pkg.sv
package rx_reset_seq_pkg;
  // Per-channel strobes from control to the countdown datapath
  typedef struct packed {
    logic reload;   // a holding condition is present: restart the settle count
    logic advance;  // all conditions clear: step the countdown
  } seqStrobe_t;
endpackage

// File: rtl/rx_reset_sync.sv
module rx_reset_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstIn,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageOne;

  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) begin
      stageOne <= '0;
      syncOut  <= '0;
    end else begin
      stageOne <= asyncIn;
      syncOut  <= stageOne;
    end
  end
endmodule

// File: rtl/rx_reset_ctrl.sv
module rx_reset_ctrl
  import rx_reset_seq_pkg::*;
#(
  parameter int NUM_CHAN = 4
) (
  input  logic                   clk,
  input  logic                   rstIn,
  input  logic [NUM_CHAN-1:0]    calSync,
  input  logic [NUM_CHAN-1:0]    lockSync,
  input  logic                   manualMode,
  output logic [NUM_CHAN-1:0]    anaRst,
  output seqStrobe_t [NUM_CHAN-1:0] strobe
);
  logic [NUM_CHAN-1:0] holdCond;

  // Analog reset: global reset or calibration in progress
  always_ff @(posedge clk or posedge rstIn) begin
    if (rstIn) anaRst <= '1;
    else       anaRst <= calSync;
  end

  // Lock loss counts as a holding condition only in automatic mode
  assign holdCond = calSync | anaRst | (~lockSync & {NUM_CHAN{~manualMode}});

  always_comb begin
    for (int c = 0; c < NUM_CHAN; c++) begin
      strobe[c].reload  = holdCond[c];
      strobe[c].advance = ~holdCond[c];
    end
  end
endmodule

// File: rtl/rx_reset_dpath.sv
module rx_reset_dpath
  import rx_reset_seq_pkg::*;
#(
  parameter int NUM_CHAN      = 4,
  parameter int SETTLE_CYCLES = 1000,
  parameter int READY_DELAY   = 4
) (
  input  logic                      clk,
  input  logic                      rstIn,
  input  seqStrobe_t [NUM_CHAN-1:0] strobe,
  output logic [NUM_CHAN-1:0]       digRst,
  output logic [NUM_CHAN-1:0]       chanReady
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [CNT_W-1:0]       settleCnt;
    logic [READY_DELAY-1:0] readyPipe;
    logic [READY_DELAY-1:0] readyPipeNext;

    // Settle countdown and digital reset flag
    always_ff @(posedge clk or posedge rstIn) begin
      if (rstIn) begin
        settleCnt <= CNT_LOAD;
        digRst[c] <= 1'b1;
      end else if (strobe[c].reload) begin
        settleCnt <= CNT_LOAD;
        digRst[c] <= 1'b1;
      end else if (strobe[c].advance) begin
        if (settleCnt == '0) digRst[c] <= 1'b0;
        else                 settleCnt <= settleCnt - 1'b1;
      end
    end

    // Ready delay pipe: fills with ones once digital reset is released
    if (READY_DELAY == 1) begin : g_short
      assign readyPipeNext = 1'b1;
    end else begin : g_long
      assign readyPipeNext = {readyPipe[READY_DELAY-2:0], 1'b1};
    end

    always_ff @(posedge clk or posedge rstIn) begin
      if (rstIn)                               readyPipe <= '0;
      else if (strobe[c].reload || digRst[c])  readyPipe <= '0;
      else                                     readyPipe <= readyPipeNext;
    end

    assign chanReady[c] = readyPipe[READY_DELAY-1];
  end
endmodule

// File: rtl/rx_reset_seq.sv
module rx_reset_seq
  import rx_reset_seq_pkg::*;
#(
  parameter int NUM_CHAN      = 4,
  parameter int SETTLE_CYCLES = 1000,
  parameter int READY_DELAY   = 4
) (
  input  logic                clk,
  input  logic                rstIn,
  input  logic [NUM_CHAN-1:0] calBusyIn,
  input  logic [NUM_CHAN-1:0] cdrLockedIn,
  input  logic                manualMode,
  output logic [NUM_CHAN-1:0] anaRst,
  output logic [NUM_CHAN-1:0] digRst,
  output logic [NUM_CHAN-1:0] chanReady
);
  logic [NUM_CHAN-1:0]       calSync;
  logic [NUM_CHAN-1:0]       lockSync;
  seqStrobe_t [NUM_CHAN-1:0] strobe;

  rx_reset_sync #(.WIDTH(NUM_CHAN)) u_calSync (
    .clk(clk), .rstIn(rstIn), .asyncIn(calBusyIn), .syncOut(calSync)
  );

  rx_reset_sync #(.WIDTH(NUM_CHAN)) u_lockSync (
    .clk(clk), .rstIn(rstIn), .asyncIn(cdrLockedIn), .syncOut(lockSync)
  );

  rx_reset_ctrl #(.NUM_CHAN(NUM_CHAN)) u_ctrl (
    .clk(clk), .rstIn(rstIn), .calSync(calSync), .lockSync(lockSync),
    .manualMode(manualMode), .anaRst(anaRst), .strobe(strobe)
  );

  rx_reset_dpath #(
    .NUM_CHAN(NUM_CHAN), .SETTLE_CYCLES(SETTLE_CYCLES), .READY_DELAY(READY_DELAY)
  ) u_dpath (
    .clk(clk), .rstIn(rstIn), .strobe(strobe),
    .digRst(digRst), .chanReady(chanReady)
  );
endmodule

// File: rtl/rx_reset_seq_chk.sv
module rx_reset_seq_chk #(
  parameter int NUM_CHAN = 4
) (
  input logic                clk,
  input logic                rstIn,
  input logic                manualMode,
  input logic [NUM_CHAN-1:0] anaRst,
  input logic [NUM_CHAN-1:0] digRst,
  input logic [NUM_CHAN-1:0] chanReady
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chk
    // R2
    digrst_covers_ana_chk: assert property (@(posedge clk) disable iff (rstIn)
      !digRst[c] |-> !anaRst[c]);
    // R4
    ready_needs_release_chk: assert property (@(posedge clk) disable iff (rstIn)
      chanReady[c] |-> !digRst[c]);
    // R4
    ready_rise_after_release_chk: assert property (@(posedge clk) disable iff (rstIn)
      $rose(chanReady[c]) |-> $past(!digRst[c]));
    // R6
    manual_lock_ignored_chk: assert property (@(posedge clk) disable iff (rstIn)
      ($rose(digRst[c]) && manualMode && $past(manualMode)) |-> anaRst[c]);
    // R10
    cal_same_edge_chk: assert property (@(posedge clk) disable iff (rstIn)
      $rose(anaRst[c]) |-> digRst[c]);
  end
endmodule

bind rx_reset_seq rx_reset_seq_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk(clk), .rstIn(rstIn), .manualMode(manualMode),
  .anaRst(anaRst), .digRst(digRst), .chanReady(chanReady)
);

// File: tb/rx_reset_seq_tb.sv
module rx_reset_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 3;
  localparam int SETTLE     = 20;
  localparam int RDLY       = 4;

  logic           clk = 1'b0;
  logic           rstIn;
  logic [NCH-1:0] calBusyIn;
  logic [NCH-1:0] cdrLockedIn;
  logic           manualMode;
  logic [NCH-1:0] anaRst;
  logic [NCH-1:0] digRst;
  logic [NCH-1:0] chanReady;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_reset_seq #(.NUM_CHAN(NCH), .SETTLE_CYCLES(SETTLE), .READY_DELAY(RDLY)) u_dut (
    .clk(clk), .rstIn(rstIn), .calBusyIn(calBusyIn), .cdrLockedIn(cdrLockedIn),
    .manualMode(manualMode), .anaRst(anaRst), .digRst(digRst), .chanReady(chanReady)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts falling edges until the selected output of channel ch reaches level.
  // sel: 0 digRst, 1 anaRst, 2 chanReady. leak reports ready seen high on the way.
  task automatic waitLevel(input int ch, input int sel, input bit level,
                           output int n, output bit leak);
    bit v;
    n = 0; leak = 1'b0;
    do begin
      @(negedge clk);
      n++;
      v = (sel == 0) ? digRst[ch] : (sel == 1) ? anaRst[ch] : chanReady[ch];
      if (sel != 2 && v != level && chanReady[ch]) leak = 1'b1;
    end while (v != level && n < 4 * SETTLE + 50);
  endtask

  task automatic testReset();
    int n; bit leak;
    rstIn = 1'b1; calBusyIn = '0; cdrLockedIn = '1; manualMode = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R7 analog reset in reset",  anaRst,    (1 << NCH) - 1);
    checkEq("R2 digital reset in reset", digRst,    (1 << NCH) - 1);
    checkEq("R4 ready low in reset",     chanReady, 0);
    checkEq("R9 vector width", $bits(chanReady) + $bits(digRst) + $bits(anaRst), 3 * NCH);
    rstIn = 1'b0;
    waitLevel(0, 0, 1'b0, n, leak);
    checkEq("R3 release edges after reset", n, SETTLE + 3);
    checkEq("R4 ready low during countdown", leak, 0);
    checkEq("R1 analog reset follows cal", anaRst, 0);
    checkEq("R8 all channels released together", digRst, 0);
    waitLevel(0, 2, 1'b1, n, leak);
    checkEq("R4 ready delay", n, RDLY);
    checkEq("R4 all ready", chanReady, (1 << NCH) - 1);
  endtask

  task automatic testLockLoss();
    int n; bit leak; bit otherDrop = 1'b0;
    @(negedge clk);
    cdrLockedIn[1] = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (chanReady[0] !== 1'b1 || chanReady[2] !== 1'b1) otherDrop = 1'b1;
    end while (digRst[1] == 1'b0 && n < 20);
    checkEq("R10 lock loss raise edges", n, 3);
    checkEq("R4 ready falls with reset", chanReady[1], 0);
    checkEq("R2 no analog reset on lock loss", anaRst[1], 0);
    repeat (5) begin
      @(negedge clk);
      if (chanReady[0] !== 1'b1 || chanReady[2] !== 1'b1) otherDrop = 1'b1;
    end
    checkEq("R8 other channels undisturbed", otherDrop, 0);
    cdrLockedIn[1] = 1'b1;
    waitLevel(1, 0, 1'b0, n, leak);
    checkEq("R3 release after relock", n, SETTLE + 3);
    waitLevel(1, 2, 1'b1, n, leak);
    checkEq("R4 ready after relock", n, RDLY);
  endtask

  task automatic testReload();
    int n; bit leak;
    @(negedge clk);
    cdrLockedIn[2] = 1'b0;
    repeat (4) @(negedge clk);
    cdrLockedIn[2] = 1'b1;
    waitLevel(2, 0, 1'b1, n, leak);
    repeat (5) @(negedge clk);
    cdrLockedIn[2] = 1'b0;            // glitch during countdown
    @(negedge clk);
    cdrLockedIn[2] = 1'b1;
    waitLevel(2, 0, 1'b0, n, leak);
    checkEq("R5 reload delays release", n + 1, SETTLE + 4);
    checkEq("R5 ready held low", leak, 0);
    waitLevel(2, 2, 1'b1, n, leak);
    checkEq("R5 ready after reload", n, RDLY);
  endtask

  task automatic testCal();
    int n; bit leak;
    @(negedge clk);
    calBusyIn[2] = 1'b1;
    waitLevel(2, 1, 1'b1, n, leak);
    checkEq("R1 analog reset raise edges", n, 3);
    checkEq("R10 digital reset same edge", digRst[2], 1);
    checkEq("R8 neighbour ready kept", chanReady[1:0], 3);
    calBusyIn[2] = 1'b0;
    waitLevel(2, 1, 1'b0, n, leak);
    checkEq("R1 analog reset fall edges", n, 3);
    waitLevel(2, 0, 1'b0, n, leak);
    checkEq("R3 release after cal", n + 3, SETTLE + 4);
    waitLevel(2, 2, 1'b1, n, leak);
    checkEq("R4 ready after cal", n, RDLY);
  endtask

  task automatic testManual();
    int n; bit leak; bit held = 1'b1;
    @(negedge clk);
    manualMode = 1'b1;
    repeat (2) @(negedge clk);
    cdrLockedIn[0] = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (digRst[0] !== 1'b0 || chanReady[0] !== 1'b1) held = 1'b1 & 1'b0;
    end
    checkEq("R6 lock loss ignored in manual", held, 1);
    calBusyIn[0] = 1'b1;
    waitLevel(0, 0, 1'b1, n, leak);
    checkEq("R6 cal still honoured in manual", n, 3);
    calBusyIn[0] = 1'b0; cdrLockedIn[0] = 1'b1; manualMode = 1'b0;
    waitLevel(0, 0, 1'b0, n, leak);
    checkEq("R3 release after manual cal", n, SETTLE + 4);
    waitLevel(0, 2, 1'b1, n, leak);
    checkEq("R4 ready after manual cal", n, RDLY);
  endtask

  task automatic testGlobalReset();
    int n; bit leak;
    @(negedge clk);
    #2 rstIn = 1'b1;
    #1;
    checkEq("R7 async analog reset",  anaRst,    (1 << NCH) - 1);
    checkEq("R7 async digital reset", digRst,    (1 << NCH) - 1);
    checkEq("R7 async ready clear",   chanReady, 0);
    @(negedge clk);
    rstIn = 1'b0;
    waitLevel(1, 0, 1'b0, n, leak);
    checkEq("R7 synchronous release", n, SETTLE + 3);
    waitLevel(1, 2, 1'b1, n, leak);
    checkEq("R7 ready after reset", chanReady, (1 << NCH) - 1);
  endtask

  initial begin
    testReset();
    testLockLoss();
    testReload();
    testCal();
    testManual();
    testGlobalReset();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule